// File: doc/BRIEF.md
# Doubleword Shift and Rotate Unit

This block shifts or rotates a 64-bit operand for an integer datapath that works on doublewords. Four kinds of movement are offered: logical left, logical right, arithmetic right and rotate right. The amount comes in one of three forms: a 5-bit field taken from the instruction word, the same field with half the word width added to it so that amounts 32 to 63 can be reached, or the low six bits of a second register operand.

The datapath is combinational. An output register, selected by a parameter and on by default, gives the result one clock after the inputs are presented. The caller decodes the instruction into a 4-bit operation code and supplies the operand, the immediate field and the amount register in the same cycle.

Top module: `dsr_shift_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, result_o becomes zero on that edge and stays zero until the first edge with rst_n high.
- R2: With the output register enabled, result_o shows the result of the inputs sampled on a rising edge from that edge until the next one (one cycle of latency).
- R3: Operation codes with op_i[3:2] = 00 shift by the value of imm_i, from 0 to 31.
- R4: Operation codes with op_i[3:2] = 01 shift by the value of imm_i plus 32, from 32 to 63.
- R5: Operation codes with op_i[3:2] = 10 shift by amount_i[5:0]; bits 63 to 6 of amount_i have no effect on the result.
- R6: op_i[1:0] = 00 shifts left and fills the vacated low bits with zeros.
- R7: op_i[1:0] = 01 shifts right and fills the vacated high bits with zeros.
- R8: op_i[1:0] = 10 shifts right and fills the vacated high bits with copies of operand bit 63.
- R9: op_i[1:0] = 11 rotates right by n, giving (x >> n) | (x << (64 - n)); an effective amount of zero returns the operand unchanged.
- R10: Operation codes with op_i[3:2] = 11 are unused and give a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous reset, active low |
| operand_i | input | 64 | Value to be shifted or rotated |
| imm_i | input | 5 | Shift amount field from the instruction |
| amount_i | input | 64 | Register operand whose low six bits give the variable amount |
| op_i | input | 4 | Operation code: bits 3:2 pick the amount form, bits 1:0 the shift kind |
| result_o | output | 64 | Shifted or rotated result |

## Verification
Two functions meet in one cycle when a variable rotate is given an amount register whose low six bits are zero but whose upper bits are not, such as 64 or 128: the masking of the amount and the zero-amount rule of the rotate both act at once, and the result must be the operand unchanged. The bench provokes this directly and also sweeps every operation code over all 64 amounts with random upper amount bits and random operands, judging each cycle's registered result against a behavioural model built on the language's own shift operators.

// File: rtl/dsr_pkg.sv
// Package: shared encodings for the doubleword shift unit.
// Assumes op code bits [1:0] select the kind and bits [3:2] the amount form.
package dsr_pkg;

    // Kind of movement applied to the operand.
    typedef enum logic [1:0] {
        SK_LEFT  = 2'b00,
        SK_RIGHT = 2'b01,
        SK_ARITH = 2'b10,
        SK_ROTR  = 2'b11
    } shift_kind_e;

    // Where the shift amount comes from.
    typedef enum logic [1:0] {
        AF_IMM    = 2'b00,
        AF_IMM_HI = 2'b01,
        AF_REG    = 2'b10,
        AF_NONE   = 2'b11
    } amt_form_e;

    // Decoded view of an operation code.
    typedef struct packed {
        amt_form_e   form;
        shift_kind_e kind;
    } shift_op_t;

endpackage

// File: rtl/dsr_amount.sv
// Module: dsr_amount
// Turns the amount form and its sources into one shift count and a flag
// that forces the result to zero for the unused form.
// Assumes DATA_W is a power of two; IMM_W is one bit narrower than the count.
module dsr_amount
    import dsr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DATA_W),
    parameter int IMM_W  = CNT_W - 1
) (
    input  amt_form_e          form_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [DATA_W-1:0]  amount_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               zero_o
);

    localparam logic [CNT_W-1:0] HALF = CNT_W'(DATA_W / 2);

    // Upper amount bits are deliberately ignored; collected to mark intent.
    logic unused_amount_hi;
    assign unused_amount_hi = ^amount_i[DATA_W-1:CNT_W];

    // Select the effective count for the requested form.
    always_comb begin
        cnt_o  = '0;
        zero_o = 1'b0;
        unique case (form_i)
            AF_IMM:    cnt_o = CNT_W'(imm_i);
            AF_IMM_HI: cnt_o = CNT_W'(imm_i) + HALF;
            AF_REG:    cnt_o = amount_i[CNT_W-1:0];
            default:   zero_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/dsr_core.sv
// Module: dsr_core
// Logarithmic barrel shifter. Left shifts are done by mirroring the word,
// shifting right and mirroring back, so one right-moving ladder serves all
// four kinds. Each rung moves by a power of two; the bits entering from the
// top are zeros, sign copies, or the bits leaving at the bottom (rotate).
// Assumes DATA_W is a power of two and CNT_W = log2(DATA_W).
module dsr_core
    import dsr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  shift_kind_e       kind_i,
    input  logic              zero_i,
    output logic [DATA_W-1:0] dout_o
);

    logic [DATA_W-1:0] mirrored_in;
    logic [DATA_W-1:0] mirrored_out;
    logic [DATA_W-1:0] ladder_in;
    logic [DATA_W-1:0] rung [CNT_W+1];
    logic              fill_bit;
    logic              is_left;
    logic              is_rot;

    assign is_left = (kind_i == SK_LEFT);
    assign is_rot  = (kind_i == SK_ROTR);

    // Sign copy for arithmetic right, zero for the logical kinds.
    assign fill_bit = (kind_i == SK_ARITH) ? din_i[DATA_W-1] : 1'b0;

    // Bit mirror of the input and of the ladder output.
    for (genvar b = 0; b < DATA_W; b++) begin : g_mirror
        assign mirrored_in[b]  = din_i[DATA_W-1-b];
        assign mirrored_out[b] = rung[CNT_W][DATA_W-1-b];
    end

    assign ladder_in = is_left ? mirrored_in : din_i;
    assign rung[0]   = ladder_in;

    // One rung per count bit, moving right by 2**s when that bit is set.
    for (genvar s = 0; s < CNT_W; s++) begin : g_rung
        localparam int DIST = 1 << s;
        logic [DATA_W-1:0] moved;
        assign moved = is_rot
                     ? {rung[s][DIST-1:0], rung[s][DATA_W-1:DIST]}
                     : {{DIST{fill_bit}}, rung[s][DATA_W-1:DIST]};
        assign rung[s+1] = cnt_i[s] ? moved : rung[s];
    end

    // Undo the mirror for left shifts and blank the unused form.
    always_comb begin
        if (zero_i)       dout_o = '0;
        else if (is_left) dout_o = mirrored_out;
        else              dout_o = rung[CNT_W];
    end

endmodule

// File: rtl/dsr_outreg.sv
// Module: dsr_outreg
// Optional timing register at the result. When ENABLE is 1 the value is
// captured every rising edge with a synchronous active-low clear; when 0
// the value passes straight through.
module dsr_outreg #(
    parameter int DATA_W = 64,
    parameter bit ENABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);

    if (ENABLE) begin : g_reg
        logic [DATA_W-1:0] q_r;
        // Capture the result, clearing it during reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= d_i;
        end
        assign q_o = q_r;
    end else begin : g_wire
        logic unused_ctl;
        assign unused_ctl = clk ^ rst_n;
        assign q_o = d_i;
    end

endmodule

// File: rtl/dsr_shift_unit.sv
// Module: dsr_shift_unit (top)
// Doubleword shift and rotate unit: decodes the 4-bit operation code into a
// kind and an amount form, forms the count, runs the barrel shifter and
// optionally registers the result. Assumes the caller holds inputs stable
// around the rising edge that captures them.
module dsr_shift_unit
    import dsr_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int IMM_W   = $clog2(DATA_W) - 1,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] amount_i,
    input  logic [3:0]        op_i,
    output logic [DATA_W-1:0] result_o
);

    localparam int CNT_W = $clog2(DATA_W);

    shift_op_t         op_dec;
    logic [CNT_W-1:0]  cnt;
    logic              force_zero;
    logic [DATA_W-1:0] core_out;

    // Split the code into form and kind fields.
    assign op_dec = shift_op_t'(op_i);

    dsr_amount #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .IMM_W  (IMM_W)
    ) i_amount (
        .form_i   (op_dec.form),
        .imm_i    (imm_i),
        .amount_i (amount_i),
        .cnt_o    (cnt),
        .zero_o   (force_zero)
    );

    dsr_core #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) i_core (
        .din_i  (operand_i),
        .cnt_i  (cnt),
        .kind_i (op_dec.kind),
        .zero_i (force_zero),
        .dout_o (core_out)
    );

    dsr_outreg #(
        .DATA_W (DATA_W),
        .ENABLE (OUT_REG)
    ) i_outreg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (core_out),
        .q_o   (result_o)
    );

    // Checks on the datapath, relating the count stage to the ladder output.
    AST_SLL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_dec.kind == SK_LEFT && !force_zero && cnt != '0) |-> core_out[0] == 1'b0); // R6
    AST_SRL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_dec.kind == SK_RIGHT && !force_zero && cnt != '0) |-> core_out[DATA_W-1] == 1'b0); // R7
    AST_SRA_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_dec.kind == SK_ARITH && !force_zero) |-> core_out[DATA_W-1] == operand_i[DATA_W-1]); // R8
    AST_ROT_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_dec.kind == SK_ROTR && !force_zero) |-> $countones(core_out) == $countones(operand_i)); // R9
    AST_ROT_ZERO_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (op_dec.kind == SK_ROTR && !force_zero && cnt == '0) |-> core_out == operand_i); // R9

    if (OUT_REG) begin : g_reg_checks
        AST_UNUSED_FORM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i[3:2] == 2'b11) |=> result_o == '0); // R10
    end

endmodule

// File: tb/test_dsr_shift_unit.sv
// Bench for dsr_shift_unit: a behavioural model feeds a queue of expected
// results; inputs change on the falling edge and the registered result is
// compared on the next falling edge.
module test_dsr_shift_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] operand_i = '0;
    logic [4:0]  imm_i = '0;
    logic [63:0] amount_i = '0;
    logic [3:0]  op_i = '0;
    logic [63:0] result_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    dsr_shift_unit i_dsr_shift_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .operand_i (operand_i),
        .imm_i     (imm_i),
        .amount_i  (amount_i),
        .op_i      (op_i),
        .result_o  (result_o)
    );

    function automatic logic [63:0] model(logic [3:0] op, logic [63:0] x,
                                          logic [4:0] imm, logic [63:0] amt);
        int n;
        case (op[3:2])
            2'd0: n = int'(imm);
            2'd1: n = int'(imm) + 32;
            2'd2: n = int'(amt % 64);
            default: return 64'd0;
        endcase
        case (op[1:0])
            2'd0: return x << n;
            2'd1: return x >> n;
            2'd2: return 64'($signed(x) >>> n);
            default: return (n == 0) ? x : ((x >> n) | (x << (64 - n)));
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] op);
        if (op[3:2] == 2'd3) return "R10";
        case (op[1:0])
            2'd0: return "R6";
            2'd1: return "R7";
            2'd2: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: result %h, expected %h", tag, act, exp);
        end
    endtask

    // One cycle: judge the previous inputs, then present new ones.
    task automatic step(logic [3:0] op, logic [63:0] x, logic [4:0] imm,
                        logic [63:0] amt, string tag);
        @(negedge clk);
        if (exp_q.size() != 0) check(tag_q.pop_front(), result_o, exp_q.pop_front());
        op_i = op; operand_i = x; imm_i = imm; amount_i = amt;
        exp_q.push_back(model(op, x, imm, amt));
        tag_q.push_back(tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        // R1: inputs active during reset, output must stay zero.
        op_i = 4'b0011; operand_i = 64'hDEAD_BEEF_0123_4567; imm_i = 5'd3;
        repeat (3) @(negedge clk);
        check("R1", result_o, 64'd0);
        @(negedge clk);
        check("R1", result_o, 64'd0);
        rst_n = 1'b1;

        // R2: first result appears one edge after it is presented.
        step(4'b0001, 64'h8000_0000_0000_0001, 5'd1, 64'd0, "R2");
        @(negedge clk);
        check(tag_q.pop_front(), result_o, exp_q.pop_front());
        check("R2", result_o, 64'h4000_0000_0000_0000);

        // Directed boundaries.
        step(4'b0001, 64'hFFFF_FFFF_FFFF_FFFF, 5'd31, 64'd0, "R3");
        step(4'b0100, 64'h0000_0000_1234_5678, 5'd0, 64'd0, "R4");
        step(4'b0110, 64'h8000_0000_0000_0000, 5'd31, 64'd0, "R4");
        step(4'b1011, 64'h0123_4567_89AB_CDEF, 5'd7, 64'd64, "R5");
        step(4'b1011, 64'h0123_4567_89AB_CDEF, 5'd7, 64'd128, "R5");
        step(4'b1000, 64'd1, 5'd0, 64'hFFFF_FFFF_FFFF_FFC3, "R5");
        step(4'b0011, 64'hF0F0_0000_0000_000F, 5'd0, 64'd0, "R9");
        step(4'b1111, 64'hFFFF_FFFF_FFFF_FFFF, 5'd9, 64'd9, "R10");
        step(4'b0010, 64'h8000_0000_0000_0000, 5'd31, 64'd0, "R8");
        step(4'b0110, 64'h8000_0000_0000_0000, 5'd31, 64'd0, "R8");

        // Sweep: every code, every amount, random operand and upper bits.
        for (int op = 0; op < 16; op++) begin
            for (int n = 0; n < 64; n++) begin
                logic [63:0] x;
                logic [63:0] amt;
                x   = {$urandom(), $urandom()};
                amt = {$urandom(), $urandom()};
                amt[5:0] = 6'(n);
                step(4'(op), x, 5'(n), amt, (op[3:2] == 2'd2) ? "R5" : tag_of(4'(op)));
            end
        end

        step(4'b1100, 64'd0, 5'd0, 64'd0, "R10");
        @(negedge clk);
        check(tag_q.pop_front(), result_o, exp_q.pop_front());

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule